// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload Timer

A 16-bit timer/counter that counts either prescaled system clock ticks or falling edges on an external count pin. A second external pin, the control pin, serves as a capture strobe, a reload strobe or a direction select, depending on the mode. A paired 16-bit capture/reload register either latches the running count or supplies the value that is loaded when the counter rolls over. In clock-output mode the block drives a square wave whose half period is set by that register.

Software reaches the block through a byte-wide register port. The port covers a mode byte, the two capture/reload bytes and the two count bytes. Four control levels come from the neighbouring timer control logic: run, capture select, external-strobe enable and counter select. A fifth level, the speed select, picks the timer-mode prescaler. Rollover and control-edge events are reported as one-cycle pulses. The interrupt logic turns these pulses into sticky flags.

Top module: `cr_timer16`

## Requirements
- R1: After reset the mode byte reads E4h (bits 7:5 and bit 2 set, all others clear), both capture bytes and both count bytes read 00h, and the rollover pulse, edge pulse, clock output and clock-output enable are all 0.
- R2: Register addresses are 0 for the mode byte, 1 for capture low, 2 for capture high, 3 for count low and 4 for count high. Every byte reads back what was last written. In the mode byte, bit 0 is the down-count enable, bit 1 is the clock-output enable and bit 3 selects the divide-by-13 source. The other mode bits are plain storage.
- R3: In timer mode (counter select 0) the count advances once every 12 system clocks when the speed select is 0, and once every 4 system clocks when it is 1.
- R4: In counter mode with mode bit 3 clear, the count advances once per falling edge of the count pin, seen through a two-flop synchronizer. In counter mode with mode bit 3 set, the count advances once every 13 system clocks, whatever the speed select.
- R5: In reload mode (capture select 0), an up count from FFFFh loads the capture/reload value and raises the rollover pulse for one cycle.
- R6: With the down-count enable clear, the count always goes up, whatever the control pin level. With the enable set, the count goes up while the control pin is 1 and down while it is 0.
- R7: On a down count, a count equal to the reload value loads FFFFh and raises the rollover pulse. Any other count decrements without a pulse.
- R8: In capture mode the count goes up and wraps from FFFFh to 0000h with a rollover pulse. When the strobe enable is set, a falling edge on the control pin copies the count into the capture bytes and raises the edge pulse, and the count carries on unchanged.
- R9: In reload mode with the down-count enable clear and the strobe enable set, a falling edge on the control pin loads the count from the reload value and raises the edge pulse.
- R10: With the strobe enable clear, control-pin edges cause no capture, no reload and no edge pulse.
- R11: With mode bit 1 set in timer mode, the clock-output enable is 1. Each rollover reloads the count and toggles the clock output, so each half period lasts (65536 − reload) count ticks. No rollover pulse is raised.
- R12: With run at 0 the count holds, whatever the count source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| ctl_pin_i | input | 1 | External control pin (strobe or direction), asynchronous |
| run_i | input | 1 | Counting enable |
| capture_i | input | 1 | 1 = capture mode, 0 = reload mode |
| ext_en_i | input | 1 | Enables control-pin strobe actions |
| counter_i | input | 1 | 1 = counter mode, 0 = timer mode |
| fast_i | input | 1 | Timer prescaler: 0 = divide by 12, 1 = divide by 4 |
| reg_we_i | input | 1 | Byte write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| ovf_o | output | 1 | One-cycle rollover pulse |
| exf_o | output | 1 | One-cycle control-edge pulse |
| clk_out_o | output | 1 | Clock-output level |
| clk_out_en_o | output | 1 | Clock-output drive enable |

## Verification
A wrong prescaler phase or divider count shows up as a count that changes at the wrong spacing. This is visible at the read port within one prescale period, at most 13 cycles. A wrong direction decision, or a wrong compare against the reload value, leaves a count one step away from the expected value after a single count edge. It also either drops or adds a rollover pulse at the boundary. A capture path that is stale or mistimed leaves capture bytes that differ from the count that was held before the strobe. Corrupted clock-output state appears as a wrong toggle spacing on the very next half period.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned BYTE_W = 8;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        RA_MODE   = 3'd0,
        RA_CAP_LO = 3'd1,
        RA_CAP_HI = 3'd2,
        RA_CNT_LO = 3'd3,
        RA_CNT_HI = 3'd4
    } reg_addr_e;

    localparam byte_t MODE_RST   = 8'hE4;
    localparam int    MB_DOWN_EN = 0;
    localparam int    MB_OUT_EN  = 1;
    localparam int    MB_DIV13   = 3;

    typedef struct packed {
        logic run;
        logic capture;
        logic ext_en;
        logic counter;
    } ctrl_t;

    typedef struct packed {
        logic tick;
        logic ext_fall;
        logic ext_level;
    } evt_t;

    function automatic cnt_t merge_byte(cnt_t cur, byte_t b, logic hi);
        return hi ? {b, cur[BYTE_W-1:0]} : {cur[CNT_W-1:BYTE_W], b};
    endfunction

endpackage

// File: rtl/crt_divider.sv
module crt_divider #(
    parameter int unsigned N = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1;

    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == W'(N - 1));

    always_ff @(posedge clk) begin
        if (rst || tick_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // R3 / R4: a prescaler tick is never followed by another on the next cycle
    a_r3_div_gap: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/crt_prescale.sv
module crt_prescale
    import crt_pkg::*;
#(
    parameter int unsigned DIV_SLOW    = 12,
    parameter int unsigned DIV_FAST    = 4,
    parameter int unsigned DIV_ALT     = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cnt_pin_i,
    input  logic ctl_pin_i,
    input  logic counter_i,
    input  logic fast_i,
    input  logic div13_i,
    output evt_t evt_o
);
    localparam int unsigned NDIV = 3;
    localparam int unsigned DIVS [NDIV] = '{DIV_SLOW, DIV_FAST, DIV_ALT};

    logic [NDIV-1:0]        div_tick;
    logic [SYNC_STAGES-1:0] pin_sync_q, ctl_sync_q;
    logic                   pin_prev_q, ctl_prev_q;
    logic                   pin_s, ctl_s, pin_fall;

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        crt_divider #(.N(DIVS[g])) u_div (
            .clk    (clk),
            .rst    (rst),
            .tick_o (div_tick[g])
        );
    end

    assign pin_s = pin_sync_q[SYNC_STAGES-1];
    assign ctl_s = ctl_sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sync_q <= '1;
            ctl_sync_q <= '1;
            pin_prev_q <= 1'b1;
            ctl_prev_q <= 1'b1;
        end else begin
            pin_sync_q <= {pin_sync_q[SYNC_STAGES-2:0], cnt_pin_i};
            ctl_sync_q <= {ctl_sync_q[SYNC_STAGES-2:0], ctl_pin_i};
            pin_prev_q <= pin_s;
            ctl_prev_q <= ctl_s;
        end
    end

    assign pin_fall = pin_prev_q && !pin_s;

    always_comb begin
        if (counter_i) evt_o.tick = div13_i ? div_tick[2] : pin_fall;
        else           evt_o.tick = fast_i  ? div_tick[1] : div_tick[0];
        evt_o.ext_fall  = ctl_prev_q && !ctl_s;
        evt_o.ext_level = ctl_s;
    end

endmodule

// File: rtl/crt_core.sv
module crt_core
    import crt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ctrl_t       ctrl_i,
    input  evt_t        evt_i,
    input  logic        reg_we_i,
    input  logic [2:0]  reg_addr_i,
    input  byte_t       reg_wdata_i,
    output byte_t       reg_rdata_o,
    output logic        div13_o,
    output logic        ovf_o,
    output logic        exf_o,
    output logic        clk_out_o,
    output logic        clk_out_en_o
);
    byte_t mode_q;
    cnt_t  cnt_q, cnt_n, cap_q, cap_n;
    logic  ovf_q, exf_q, tgl_q;
    logic  clkout_mode, capture_eff, dir_up, step, ext_hit, roll;
    logic  wr_mode, wr_cap_lo, wr_cap_hi, wr_cnt_lo, wr_cnt_hi, wr_cnt, wr_cap;

    assign wr_mode   = reg_we_i && (reg_addr_i == RA_MODE);
    assign wr_cap_lo = reg_we_i && (reg_addr_i == RA_CAP_LO);
    assign wr_cap_hi = reg_we_i && (reg_addr_i == RA_CAP_HI);
    assign wr_cnt_lo = reg_we_i && (reg_addr_i == RA_CNT_LO);
    assign wr_cnt_hi = reg_we_i && (reg_addr_i == RA_CNT_HI);
    assign wr_cnt    = wr_cnt_lo || wr_cnt_hi;
    assign wr_cap    = wr_cap_lo || wr_cap_hi;

    assign clkout_mode = mode_q[MB_OUT_EN] && !ctrl_i.counter;
    assign capture_eff = ctrl_i.capture && !clkout_mode;
    assign dir_up      = clkout_mode || capture_eff || !mode_q[MB_DOWN_EN] || evt_i.ext_level;
    assign step        = ctrl_i.run && evt_i.tick;
    assign ext_hit     = ctrl_i.ext_en && evt_i.ext_fall && !clkout_mode
                         && (capture_eff || !mode_q[MB_DOWN_EN]);

    always_comb begin
        cnt_n = cnt_q;
        cap_n = cap_q;
        roll  = 1'b0;
        if (step) begin
            if (dir_up) begin
                if (cnt_q == '1) begin
                    roll  = 1'b1;
                    cnt_n = capture_eff ? '0 : cap_q;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end else if (cnt_q == cap_q) begin
                roll  = 1'b1;
                cnt_n = '1;
            end else begin
                cnt_n = cnt_q - 1'b1;
            end
        end
        if (ext_hit) begin
            if (capture_eff) cap_n = cnt_q;
            else             cnt_n = cap_q;
        end
        if (wr_cnt_lo) cnt_n = merge_byte(cnt_n, reg_wdata_i, 1'b0);
        if (wr_cnt_hi) cnt_n = merge_byte(cnt_n, reg_wdata_i, 1'b1);
        if (wr_cap_lo) cap_n = merge_byte(cap_n, reg_wdata_i, 1'b0);
        if (wr_cap_hi) cap_n = merge_byte(cap_n, reg_wdata_i, 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            cnt_q  <= '0;
            cap_q  <= '0;
            ovf_q  <= 1'b0;
            exf_q  <= 1'b0;
            tgl_q  <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= reg_wdata_i;
            cnt_q <= cnt_n;
            cap_q <= cap_n;
            ovf_q <= roll && !clkout_mode;
            exf_q <= ext_hit;
            if (roll && clkout_mode) tgl_q <= !tgl_q;
        end
    end

    always_comb begin
        case (reg_addr_i)
            RA_MODE:   reg_rdata_o = mode_q;
            RA_CAP_LO: reg_rdata_o = cap_q[BYTE_W-1:0];
            RA_CAP_HI: reg_rdata_o = cap_q[CNT_W-1:BYTE_W];
            RA_CNT_LO: reg_rdata_o = cnt_q[BYTE_W-1:0];
            RA_CNT_HI: reg_rdata_o = cnt_q[CNT_W-1:BYTE_W];
            default:   reg_rdata_o = '0;
        endcase
    end

    assign div13_o      = mode_q[MB_DIV13];
    assign ovf_o        = ovf_q;
    assign exf_o        = exf_q;
    assign clk_out_o    = tgl_q;
    assign clk_out_en_o = clkout_mode;

    // R5: up count out of FFFFh in reload mode lands on the reload value with a pulse
    a_r5_up_reload: assert property (@(posedge clk) disable iff (rst)
        (step && dir_up && cnt_q == '1 && !capture_eff && !clkout_mode && !ext_hit && !wr_cnt && !wr_cap)
        |=> (cnt_q == $past(cap_q)) && ovf_o);

    // R7: down count at the reload value wraps to FFFFh with a pulse
    a_r7_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !dir_up && cnt_q == cap_q && !ext_hit && !wr_cnt)
        |=> (cnt_q == '1) && ovf_o);

    // R8: a capture strobe records the count held before the edge
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        (ext_hit && capture_eff && !wr_cap)
        |=> (cap_q == $past(cnt_q)) && exf_o);

    // R11: clock-output mode never raises the rollover pulse
    a_r11_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (clkout_mode && $past(clkout_mode)) |-> !ovf_o);

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import crt_pkg::*;
#(
    parameter int unsigned DIV_SLOW    = 12,
    parameter int unsigned DIV_FAST    = 4,
    parameter int unsigned DIV_ALT     = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_pin_i,
    input  logic       ctl_pin_i,
    input  logic       run_i,
    input  logic       capture_i,
    input  logic       ext_en_i,
    input  logic       counter_i,
    input  logic       fast_i,
    input  logic       reg_we_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       ovf_o,
    output logic       exf_o,
    output logic       clk_out_o,
    output logic       clk_out_en_o
);
    ctrl_t ctrl;
    evt_t  evt;
    logic  div13;

    assign ctrl = '{run: run_i, capture: capture_i, ext_en: ext_en_i, counter: counter_i};

    crt_prescale #(
        .DIV_SLOW    (DIV_SLOW),
        .DIV_FAST    (DIV_FAST),
        .DIV_ALT     (DIV_ALT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .cnt_pin_i (cnt_pin_i),
        .ctl_pin_i (ctl_pin_i),
        .counter_i (counter_i),
        .fast_i    (fast_i),
        .div13_i   (div13),
        .evt_o     (evt)
    );

    crt_core u_core (
        .clk          (clk),
        .rst          (rst),
        .ctrl_i       (ctrl),
        .evt_i        (evt),
        .reg_we_i     (reg_we_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .div13_o      (div13),
        .ovf_o        (ovf_o),
        .exf_o        (exf_o),
        .clk_out_o    (clk_out_o),
        .clk_out_en_o (clk_out_en_o)
    );

endmodule

// File: tb/cr_timer16_bench.sv
`timescale 1ns/100ps
module cr_timer16_bench;
    import crt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_pin = 1'b1, ctl_pin = 1'b1;
    logic run = 1'b0, capture = 1'b0, ext_en = 1'b0, counter = 1'b1, fast = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic ovf, exf, clk_out, clk_out_en;

    int total = 0, fails = 0, ovf_cnt = 0, exf_cnt = 0;

    always #2.5 clk = ~clk;

    cr_timer16 u_cr_timer16 (
        .clk(clk), .rst(rst), .cnt_pin_i(cnt_pin), .ctl_pin_i(ctl_pin),
        .run_i(run), .capture_i(capture), .ext_en_i(ext_en), .counter_i(counter),
        .fast_i(fast), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ovf_o(ovf),
        .exf_o(exf), .clk_out_o(clk_out), .clk_out_en_o(clk_out_en)
    );

    always @(negedge clk) begin
        if (!rst && ovf) ovf_cnt++;
        if (!rst && exf) exf_cnt++;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo_a, input logic [15:0] v);
        wr(lo_a, v[7:0]);
        wr(lo_a + 3'd1, v[15:8]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] lo_a, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo_a, l);
        rd(lo_a + 3'd1, h);
        v = {h, l};
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic pin_pulse();
        @(negedge clk); cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_ctl(input logic lvl);
        @(negedge clk); ctl_pin = lvl;
        settle();
    endtask

    task automatic cnt_gap(input longint exp, input string tag);
        logic [15:0] a, b;
        int n;
        @(negedge clk); rd16(RA_CNT_LO, a);
        n = 0;
        do begin @(negedge clk); rd16(RA_CNT_LO, b); n++; end while (b == a && n < 100);
        a = b; n = 0;
        do begin @(negedge clk); rd16(RA_CNT_LO, b); n++; end while (b == a && n < 100);
        chk(tag, n, exp);
    endtask

    // one count step from the requirements: {rollover, next value}
    function automatic logic [16:0] model_step(logic [15:0] v, logic [15:0] rl, bit up);
        if (up) return (v == 16'hFFFF) ? {1'b1, rl} : {1'b0, v + 16'd1};
        return (v == rl) ? {1'b1, 16'hFFFF} : {1'b0, v - 16'd1};
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int o0, e0, n_t;
        void'($urandom(32'h00C0FFEE));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(RA_MODE, b);   chk("R1 mode reset", b, 8'hE4);
        rd16(RA_CAP_LO, v); chk("R1 capture reset", v, 0);
        rd16(RA_CNT_LO, v); chk("R1 count reset", v, 0);
        chk("R1 outputs reset", {ovf, exf, clk_out, clk_out_en}, 0);

        // R2: register map readback
        wr(RA_MODE, 8'h5A); rd(RA_MODE, b); chk("R2 mode readback", b, 8'h5A);
        wr(RA_MODE, 8'hE4);
        wr16(RA_CAP_LO, 16'hBEEF); rd16(RA_CAP_LO, v); chk("R2 capture readback", v, 16'hBEEF);
        wr16(RA_CNT_LO, 16'h0FF0); rd16(RA_CNT_LO, v); chk("R2 count readback", v, 16'h0FF0);

        // R12: hold while not running
        counter = 1'b1;
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R12 hold counter mode", v, 16'h0FF0);
        counter = 1'b0; repeat (40) @(negedge clk);
        rd16(RA_CNT_LO, v); chk("R12 hold timer mode", v, 16'h0FF0);

        // R4: pin edge counting
        counter = 1'b1; run = 1'b1; settle();
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R4 pin edge count", v, 16'h0FF1);

        // R5: up count reload
        wr16(RA_CAP_LO, 16'h1234); wr16(RA_CNT_LO, 16'hFFFE);
        o0 = ovf_cnt;
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R5 up to FFFF", v, 16'hFFFF);
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R5 reload after FFFF", v, 16'h1234);
        chk("R5 rollover pulse", ovf_cnt - o0, 1);

        // R6 / R7: down counting
        wr(RA_MODE, 8'hE5); set_ctl(1'b0);
        wr16(RA_CNT_LO, 16'h1236); o0 = ovf_cnt;
        pin_pulse(); pin_pulse(); rd16(RA_CNT_LO, v); chk("R7 down decrement", v, 16'h1234);
        chk("R7 no pulse above reload", ovf_cnt - o0, 0);
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R7 reload value wraps to FFFF", v, 16'hFFFF);
        chk("R7 down rollover pulse", ovf_cnt - o0, 1);
        set_ctl(1'b1); wr16(RA_CNT_LO, 16'h0010);
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R6 down enable with pin high counts up", v, 16'h0011);
        wr(RA_MODE, 8'hE4); set_ctl(1'b0);
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R6 down enable clear ignores pin", v, 16'h0012);
        set_ctl(1'b1);

        // R8: capture mode
        capture = 1'b1; ext_en = 1'b1;
        wr16(RA_CNT_LO, 16'hABCD); e0 = exf_cnt;
        set_ctl(1'b0);
        rd16(RA_CAP_LO, v); chk("R8 captured count", v, 16'hABCD);
        rd16(RA_CNT_LO, v); chk("R8 count unchanged by capture", v, 16'hABCD);
        chk("R8 edge pulse", exf_cnt - e0, 1);
        set_ctl(1'b1);
        wr16(RA_CNT_LO, 16'hFFFF); o0 = ovf_cnt;
        pin_pulse(); rd16(RA_CNT_LO, v); chk("R8 capture mode wraps to zero", v, 16'h0000);
        chk("R8 wrap pulse", ovf_cnt - o0, 1);

        // R10: strobe disabled
        ext_en = 1'b0; wr16(RA_CNT_LO, 16'h1111); e0 = exf_cnt;
        set_ctl(1'b0); set_ctl(1'b1);
        rd16(RA_CAP_LO, v); chk("R10 no capture when disabled", v, 16'hABCD);
        chk("R10 no edge pulse", exf_cnt - e0, 0);
        capture = 1'b0; set_ctl(1'b0); set_ctl(1'b1);
        rd16(RA_CNT_LO, v); chk("R10 no reload when disabled", v, 16'h1111);

        // R9: strobe reload
        ext_en = 1'b1; wr16(RA_CAP_LO, 16'h4321); wr16(RA_CNT_LO, 16'h5555); e0 = exf_cnt;
        set_ctl(1'b0);
        rd16(RA_CNT_LO, v); chk("R9 strobe reload", v, 16'h4321);
        chk("R9 edge pulse", exf_cnt - e0, 1);
        set_ctl(1'b1); ext_en = 1'b0;

        // R3 / R4: prescaler spacing
        counter = 1'b0; fast = 1'b0; cnt_gap(12, "R3 divide by 12");
        fast = 1'b1; cnt_gap(4, "R3 divide by 4");
        wr(RA_MODE, 8'hEC); counter = 1'b1; cnt_gap(13, "R4 divide by 13 fast set");
        fast = 1'b0; cnt_gap(13, "R4 divide by 13 fast clear");
        wr(RA_MODE, 8'hE4);

        // R11: clock output
        counter = 1'b0; fast = 1'b1;
        wr16(RA_CAP_LO, 16'hFFFE); wr16(RA_CNT_LO, 16'hFFFE); wr(RA_MODE, 8'hE6);
        @(negedge clk); chk("R11 output enable", clk_out_en, 1);
        begin
            logic l0;
            int n;
            n = 0; l0 = clk_out;
            do begin @(negedge clk); n++; end while (clk_out == l0 && n < 100);
            o0 = ovf_cnt; l0 = clk_out; n = 0;
            do begin @(negedge clk); n++; end while (clk_out == l0 && n < 100);
            chk("R11 half period", n, 8);
            chk("R11 no rollover pulse", ovf_cnt - o0, 0);
        end
        wr(RA_MODE, 8'hE4); counter = 1'b1;
        @(negedge clk); chk("R11 output enable off in counter mode", clk_out_en, 0);

        // R5 / R6 / R7: constrained random runs against the model
        for (int it = 0; it < 16; it++) begin
            logic [15:0] st, rl, ex;
            bit dn, lvl, up;
            int npls, rolls;
            logic [16:0] r;
            st = (it % 3 == 0) ? 16'hFFFD : 16'($urandom);
            rl = 16'($urandom);
            if (it % 4 == 1) st = rl + 16'd2;
            dn = 1'($urandom); lvl = 1'($urandom);
            npls = $urandom_range(1, 5);
            wr(RA_MODE, dn ? 8'hE5 : 8'hE4);
            set_ctl(lvl);
            wr16(RA_CAP_LO, rl); wr16(RA_CNT_LO, st);
            up = !dn || lvl; ex = st; rolls = 0;
            for (int k = 0; k < npls; k++) begin
                r = model_step(ex, rl, up);
                ex = r[15:0]; rolls += int'(r[16]);
            end
            o0 = ovf_cnt;
            for (int k = 0; k < npls; k++) pin_pulse();
            rd16(RA_CNT_LO, v); chk("R6 random count", v, ex);
            chk("R5 R7 random rollovers", ovf_cnt - o0, rolls);
        end
        n_t = total;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule